// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Programmable Pulldowns

This block is one general-purpose I/O port that sits on a simple processor register bus. Software reaches three registers through it. The first is a pin data latch, which can be read and written. The second is a per-pin direction register, also read/write. The third is a per-pin pulldown-inhibit register, which can only be written. For every pin the block drives three signals to an external pad model: an output enable, an output value and a pulldown enable.

A pin becomes an output when its direction bit is set. When a pin is an output, its pulldown is always off. When a pin is an input, its pulldown is on unless software has set the pin's inhibit bit. A static option input, which is active high, enables or disables every pulldown at once.

Reads are combinational from the address. When software reads the data register, each output pin returns its latch bit and each input pin returns its pad level after a two-flop synchroniser. The inhibit register cannot be read back, and a read of its address always returns 0x00. Reset clears the direction and inhibit registers, so after reset every pin is an input with its pulldown on. Reset does not touch the data latch.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset, pad_oe is 0x00 on every pin, and pad_pd_en equals 0xFF when sw_pd_en is 1 and 0x00 when sw_pd_en is 0.
- R2: A write to offset 0x05 loads the direction register on that clock edge. Bit i drives pad_oe[i], and a 1 makes pin i an output.
- R3: In every cycle, pad_pd_en[i] = sw_pd_en AND NOT dir[i] AND NOT inh[i], where inh is the pulldown-inhibit register.
- R4: A write to offset 0x11 loads the pulldown-inhibit register. A read of offset 0x11 always returns 0x00.
- R5: A write to offset 0x01 loads the data latch, and pad_out shows the latch from the next cycle on. Reset leaves the latch unchanged.
- R6: A read of offset 0x01 returns (dir AND latch) OR (NOT dir AND sync_in), where sync_in is pad_in delayed by two clock edges.
- R7: A register changes only on an edge where bus_wr is 1 and bus_addr matches that register's offset. Strobes to unmapped offsets, and matching addresses while bus_wr is 0, change nothing.
- R8: A read of offset 0x05 returns the direction register. A read of any unmapped offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| sw_pd_en | input | 1 | Global pulldown enable option bit, active high |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pd_en | output | 8 | Per-pin pulldown enable |

## Verification
The bench sweeps all 256 direction values against a spread of inhibit patterns, under both settings of the global option. A gating term that is missing or inverted would leave a pulldown fighting an output driver, or would leave one on while the option is clear. The bench checks that the data latch survives reset, which catches a design that wrongly clears it. It reads the inhibit address back to catch a design that leaks the register contents onto the bus. It checks the exact two-edge input latency and the mixed-direction read, so that a missing synchroniser stage or a swapped data-read multiplexer shows up. It also sends unmapped and unstrobed writes, to catch an address decoder that matches too loosely.

// File: rtl/gpio_pd_pkg.sv
// Shared types for the GPIO port: register select code from the decoder.
// Assumes the decoder resolves at most one register per address.
package gpio_pd_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_INH  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_pd_decode.sv
// Address decoder: maps a bus offset onto one register select.
// Assumes the three offsets are distinct.
module gpio_pd_decode
    import gpio_pd_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_OFS = 1,
    parameter int DIR_OFS  = 5,
    parameter int INH_OFS  = 17
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] INH_A  = ADDR_W'(INH_OFS);

    // Full-address compare to a register select.
    always_comb begin
        if (addr == DATA_A)      sel = SEL_DATA;
        else if (addr == DIR_A)  sel = SEL_DIR;
        else if (addr == INH_A)  sel = SEL_INH;
        else                     sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_pd_regs.sv
// Register storage: data latch (no reset), direction and inhibit (reset to 0).
// Assumes writes are qualified by the decoder select and bus_wr.
module gpio_pd_regs
    import gpio_pd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] inh_q
);
    // Data latch: loaded by writes, untouched by reset.
    always_ff @(posedge clk) begin
        if (wr && sel == SEL_DATA) latch_q <= wdata;
    end

    // Direction register: cleared by reset so all pins start as inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)                    dir_q <= '0;
        else if (wr && sel == SEL_DIR) dir_q <= wdata;
    end

    // Pulldown-inhibit register: cleared by reset so pulldowns start on.
    always_ff @(posedge clk) begin
        if (!rst_n)                    inh_q <= '0;
        else if (wr && sel == SEL_INH) inh_q <= wdata;
    end
endmodule

// File: rtl/gpio_pd_sync.sv
// Multi-flop synchroniser for asynchronous pad levels.
// Assumes SYNC_STAGES >= 1; the stages reset to 0.
module gpio_pd_sync #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [SYNC_STAGES];

    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pad level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // Later stages settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_pd_padctl.sv
// Per-pin pad control: output enable, output value and gated pulldown.
// Assumes the global enable is active high and static.
module gpio_pd_padctl #(
    parameter int WIDTH = 8
) (
    input  logic             glob_pd_en,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] inh,
    input  logic [WIDTH-1:0] latch,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] pd_en
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            // Output pins drive the latch; pulldown only on enabled inputs.
            always_comb begin
                oe[i]    = dir[i];
                dout[i]  = latch[i];
                pd_en[i] = glob_pd_en & ~dir[i] & ~inh[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_pd_port.sv
// GPIO port top: decoder, registers, input synchroniser, pad control and read mux.
// Assumes a single-cycle write strobe and combinational reads.
module gpio_pd_port
    import gpio_pd_pkg::*;
#(
    parameter int WIDTH        = 8,
    parameter int ADDR_W       = 5,
    parameter int DATA_OFS     = 1,
    parameter int DIR_OFS      = 5,
    parameter int INH_OFS      = 17,
    parameter int SYNC_STAGES  = 2,
    parameter int INH_READ_VAL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              sw_pd_en,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_pd_en
);
    localparam logic [WIDTH-1:0] INH_RD = WIDTH'(INH_READ_VAL);

    reg_sel_e         sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] inh_q;
    logic [WIDTH-1:0] sync_in;

    gpio_pd_decode #(
        .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .INH_OFS(INH_OFS)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_pd_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .inh_q   (inh_q)
    );

    gpio_pd_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_in)
    );

    gpio_pd_padctl #(.WIDTH(WIDTH)) u_pad (
        .glob_pd_en (sw_pd_en),
        .dir        (dir_q),
        .inh        (inh_q),
        .latch      (latch_q),
        .oe         (pad_oe),
        .dout       (pad_out),
        .pd_en      (pad_pd_en)
    );

    // Read mux: data merges latch and pad by direction; inhibit reads fixed.
    always_comb begin
        unique case (sel)
            SEL_DATA: bus_rdata = (dir_q & latch_q) | (~dir_q & sync_in);
            SEL_DIR:  bus_rdata = dir_q;
            SEL_INH:  bus_rdata = INH_RD;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pd_port_chk.sv
// Checker for gpio_pd_port, attached by bind; observes ports only.
// Assumes the default inhibit read value of zero.
module gpio_pd_port_chk #(
    parameter int WIDTH    = 8,
    parameter int ADDR_W   = 5,
    parameter int DATA_OFS = 1,
    parameter int DIR_OFS  = 5,
    parameter int INH_OFS  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              sw_pd_en,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_pd_en
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] INH_A  = ADDR_W'(INH_OFS);

    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pad_oe == '0); // R1
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_A) |=> pad_oe == $past(bus_wdata)); // R2
    AST_PD_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pd_en & (pad_oe | {WIDTH{~sw_pd_en}})) == '0); // R3
    AST_INH_UNREADABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == INH_A |-> bus_rdata == '0); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DATA_A) |=> $stable(pad_out)); // R7
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DIR_A) |=> $stable(pad_oe)); // R7
    AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == DIR_A |-> bus_rdata == pad_oe); // R8
endmodule

bind gpio_pd_port gpio_pd_port_chk #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .INH_OFS(INH_OFS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sw_pd_en  (sw_pd_en),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pd_en (pad_pd_en)
);

// File: tb/gpio_pd_port_tb_top.sv
// Self-checking bench for gpio_pd_port: sweeps direction/inhibit/option space.
module gpio_pd_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_DATA = 5'h01;
    localparam logic [4:0] A_DIR  = 5'h05;
    localparam logic [4:0] A_INH  = 5'h11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sw_pd_en = 1'b1;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pd_en;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pd_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_pd_en(sw_pd_en),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pd_en(pad_pd_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] r, inh, lat;
        @(negedge clk); @(negedge clk);
        wr(A_DATA, 8'hA5);                       // latch before reset
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pd on", pad_pd_en, 8'hFF);
        sw_pd_en = 1'b0; #1;
        check("R1 pd gated", pad_pd_en, 8'h00);
        sw_pd_en = 1'b1;
        rd(A_DIR, r);  check("R8 dir after reset", r, 8'h00);
        // R5: latch survives a second reset
        wr(A_DATA, 8'h3C);
        rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R5 latch kept over reset", pad_out, 8'h3C);
        // R2/R3/R4/R8 sweep over direction, inhibit and option
        for (int d = 0; d < 256; d++) begin
            inh = 8'((d * 37 + 11) & 8'hFF);
            wr(A_DIR, 8'(d));
            wr(A_INH, inh);
            check("R2 oe", pad_oe, 8'(d));
            for (int g = 0; g < 2; g++) begin
                sw_pd_en = g[0]; #1;
                check("R3 pd", pad_pd_en, (g[0] ? 8'hFF : 8'h00) & ~8'(d) & ~inh);
            end
            rd(A_DIR, r); check("R8 dir read", r, 8'(d));
            rd(A_INH, r); check("R4 inh read", r, 8'h00);
            @(negedge clk);
        end
        sw_pd_en = 1'b1;
        // R6: synchroniser latency on input pins
        wr(A_DIR, 8'h00);
        pad_in = 8'h00; repeat (3) @(negedge clk);
        bus_addr = A_DATA;
        pad_in = 8'h5A;
        @(negedge clk); rd(A_DATA, r); check("R6 one edge still old", r, 8'h00);
        @(negedge clk); rd(A_DATA, r); check("R6 two edges new", r, 8'h5A);
        // R5/R6: mixed direction reads
        for (int k = 0; k < 16; k++) begin
            lat = 8'((k * 29 + 3) & 8'hFF);
            wr(A_DATA, lat);
            wr(A_DIR, 8'((k * 53 + 7) & 8'hFF));
            pad_in = 8'((k * 91 + 5) & 8'hFF);
            repeat (2) @(negedge clk);
            check("R5 pad_out", pad_out, lat);
            rd(A_DATA, r);
            check("R6 mixed read", r, (pad_oe & lat) | (~pad_oe & pad_in));
        end
        // R7: strobe low and unmapped writes
        wr(A_DIR, 8'h0F); wr(A_INH, 8'h00); wr(A_DATA, 8'h81);
        bus_addr = A_DIR; bus_wdata = 8'hF0; bus_wr = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 no strobe dir", pad_oe, 8'h0F);
        for (int a = 0; a < 32; a++) begin
            if (a == A_DATA || a == A_DIR || a == A_INH) continue;
            wr(5'(a), 8'hFF);
            check("R7 unmapped dir", pad_oe, 8'h0F);
            check("R7 unmapped inh", pad_pd_en, 8'hF0);
            check("R7 unmapped data", pad_out, 8'h81);
            rd(5'(a), r); check("R8 unmapped read", r, 8'h00);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule